// File: doc/BRIEF.md
# Vector Register Scoreboard Interlock

This block sits at the issue point of a vector pipeline. It tracks which registers still have writes outstanding and holds an instruction back while any register it reads or writes is busy. The tracked state covers 32 vector registers, 32 integer registers, 8 condition fields and a single status/control flag. Each request carries a class code and a set of masks. When the block grants a request, it marks that request's destinations busy and reports how many writebacks the request will produce. Busy bits are released through a clear port as writebacks complete.

Every cycle in which a valid request is held back raises `stall`. These cycles are counted in a saturating counter, except for the first cycle of each wait. That first cycle is forgiven for the general vector classes and counted for the two status-move classes. The count shows how much time the pipeline loses to register dependencies.

Top module: `vec_scoreboard`

## Requirements
- R1: `req_ready` is low exactly when the effective vector busy set (busy bits with this cycle's `clr_vec` removed) overlaps `req_vec_in | req_vec_out`, or when another hazard from R2, R7 or R8 applies. `stall` equals `req_valid & ~req_ready`, and a grant is `req_valid & req_ready`.
- R2: Class codes are 0 vector-only, 1 integer-to-vector, 2 vector with condition update, 3 vector with status update, 4 move-from-status and 5 move-to-status; codes 6 and 7 act as code 0. Only class 1 checks the integer masks against the integer busy set; every other class ignores them.
- R3: The stall counter starts each wait by leaving the first stalled cycle uncounted, for classes 0-3 and codes 6-7. It then adds one for every further stalled cycle and saturates at all ones.
- R4: Classes 4 and 5 count every stalled cycle, including the first.
- R5: A grant ORs `req_vec_out` into the vector busy set for every class except 5. A class 1 grant also ORs `req_int_out` into the integer busy set.
- R6: `wb_count`, read during a grant, is 1 for classes 4 and 5. For other classes it is 0 if `req_vec_out` is zero, 1 if it has exactly one bit set and 2 otherwise. Class 2 adds 1 when `req_cr` is nonzero.
- R7: Class 2 also stalls while the effective condition busy set overlaps `req_cr`, and its grant ORs `req_cr` into that set.
- R8: Classes 3, 4 and 5 stall while the effective status flag is set. Grants of classes 3 and 5 set the flag.
- R9: Bits given on the clear ports are removed before the same cycle's hazard check. A busy bit that is both set by a grant and cleared in the same cycle ends up set.
- R10: Synchronous reset empties every busy set, drops the status flag and zeroes the stall counter.
- R11: While `req_valid` is high and `req_ready` is low, the requester keeps `req_valid` high and holds the class and all masks unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | No hazard; a valid request issues this cycle |
| req_class | input | 3 | Instruction class code |
| req_vec_in | input | NVEC | Vector source mask |
| req_vec_out | input | NVEC | Vector destination mask |
| req_int_in | input | NINT | Integer source mask |
| req_int_out | input | NINT | Integer destination mask |
| req_cr | input | NCR | Condition field mask |
| clr_vec | input | NVEC | Vector busy bits to release |
| clr_int | input | NINT | Integer busy bits to release |
| clr_cr | input | NCR | Condition busy bits to release |
| clr_status | input | 1 | Release the status flag |
| stall | output | 1 | Valid request held this cycle |
| stall_count | output | CNT_W | Saturating data-stall cycle count |
| wb_count | output | 2 | Writebacks owed by the request being granted |

## Verification
The assertions check several properties on every cycle. A granted destination is busy on the following cycle. A cleared bit that no grant sets is gone on the following cycle. The counter moves by at most one step at a time, and the first stalled cycle of a general-class wait leaves it unchanged. Status-setting grants raise the flag, and held requests keep their masks. Whether the forgiven-cycle rule, the class-specific hazards and the writeback arithmetic produce the right values across mixed traffic can only be shown by the bench scenarios, which compare against an independent model. Those scenarios include saturation of a narrowed counter, clear-before-check bypass and a move that counts its first stall.

// File: rtl/vec_scoreboard.sv
module vec_scoreboard #(
  parameter int NVEC  = 32,
  parameter int NINT  = 32,
  parameter int NCR   = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_class,
  input  logic [NVEC-1:0]  req_vec_in,
  input  logic [NVEC-1:0]  req_vec_out,
  input  logic [NINT-1:0]  req_int_in,
  input  logic [NINT-1:0]  req_int_out,
  input  logic [NCR-1:0]   req_cr,
  input  logic [NVEC-1:0]  clr_vec,
  input  logic [NINT-1:0]  clr_int,
  input  logic [NCR-1:0]   clr_cr,
  input  logic             clr_status,
  output logic             stall,
  output logic [CNT_W-1:0] stall_count,
  output logic [1:0]       wb_count
);
  localparam logic [2:0] CL_INTV = 3'd1;
  localparam logic [2:0] CL_CR   = 3'd2;
  localparam logic [2:0] CL_VST  = 3'd3;
  localparam logic [2:0] CL_FROM = 3'd4;
  localparam logic [2:0] CL_TO   = 3'd5;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NVEC-1:0] vbusy;
  logic [NINT-1:0] ibusy;
  logic [NCR-1:0]  cbusy;
  logic            sbusy;
  logic            wait_r;

  logic [NVEC-1:0] v_eff;
  logic [NINT-1:0] i_eff;
  logic [NCR-1:0]  c_eff;
  logic            s_eff;

  assign v_eff = vbusy & ~clr_vec;
  assign i_eff = ibusy & ~clr_int;
  assign c_eff = cbusy & ~clr_cr;
  assign s_eff = sbusy & ~clr_status;

  logic is_int, is_cr, is_vst, is_from, is_to, is_move;
  assign is_int  = req_class == CL_INTV;
  assign is_cr   = req_class == CL_CR;
  assign is_vst  = req_class == CL_VST;
  assign is_from = req_class == CL_FROM;
  assign is_to   = req_class == CL_TO;
  assign is_move = is_from | is_to;

  logic hazard, grant;
  assign hazard = (|(v_eff & (req_vec_in | req_vec_out)))
                | (is_int & |(i_eff & (req_int_in | req_int_out)))
                | (is_cr & |(c_eff & req_cr))
                | ((is_vst | is_move) & s_eff);

  assign req_ready = ~hazard;
  assign stall     = req_valid & hazard;
  assign grant     = req_valid & ~hazard;

  logic       out_one;
  logic [1:0] vec_wb;
  assign out_one = (req_vec_out & (req_vec_out - 1'b1)) == '0;
  assign vec_wb  = (req_vec_out == '0) ? 2'd0 : (out_one ? 2'd1 : 2'd2);
  assign wb_count = is_move ? 2'd1 : vec_wb + {1'b0, is_cr & |req_cr};

  logic [NVEC-1:0] set_vec;
  logic [NINT-1:0] set_int;
  logic [NCR-1:0]  set_cr;
  logic            set_st;
  assign set_vec = (grant & ~is_to) ? req_vec_out : '0;
  assign set_int = (grant & is_int) ? req_int_out : '0;
  assign set_cr  = (grant & is_cr)  ? req_cr      : '0;
  assign set_st  = grant & (is_vst | is_to);

  logic count_now;
  assign count_now = stall & (wait_r | is_move) & (stall_count != CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      vbusy       <= '0;
      ibusy       <= '0;
      cbusy       <= '0;
      sbusy       <= 1'b0;
      wait_r      <= 1'b0;
      stall_count <= '0;
    end else begin
      vbusy  <= v_eff | set_vec;
      ibusy  <= i_eff | set_int;
      cbusy  <= c_eff | set_cr;
      sbusy  <= s_eff | set_st;
      wait_r <= stall;
      if (count_now) stall_count <= stall_count + 1'b1;
    end
  end

  p_dest_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (grant && !is_to) |=> ((vbusy & $past(req_vec_out)) == $past(req_vec_out)));

  p_int_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (grant && is_int) |=> ((ibusy & $past(req_int_out)) == $past(req_int_out)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (|clr_vec) |=> ((vbusy & $past(clr_vec & ~set_vec)) == '0));

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    (stall_count != CNT_MAX) |=>
      (stall_count == $past(stall_count) || stall_count == $past(stall_count) + 1'b1));

  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (rst)
    (stall_count == CNT_MAX) |=> (stall_count == CNT_MAX));

  p_first_free_r3: assert property (@(posedge clk) disable iff (rst)
    (stall && !wait_r && !is_move) |=> (stall_count == $past(stall_count)));

  p_stat_set_r8: assert property (@(posedge clk) disable iff (rst)
    (grant && (is_vst || is_to)) |=> sbusy);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_class) && $stable(req_vec_in)
      && $stable(req_vec_out) && $stable(req_int_in) && $stable(req_int_out) && $stable(req_cr)));

  p_cr_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (grant && is_cr) |=> ((cbusy & $past(req_cr)) == $past(req_cr)));
endmodule

// File: tb/vec_scoreboard_bench.sv
`timescale 1ns/1ps
module vec_scoreboard_bench;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_class = '0;
  logic [31:0] req_vec_in = '0, req_vec_out = '0, req_int_in = '0, req_int_out = '0;
  logic [7:0] req_cr = '0;
  logic [31:0] clr_vec = '0, clr_int = '0;
  logic [7:0] clr_cr = '0;
  logic clr_status = 1'b0;
  logic req_ready, stall;
  logic [CW-1:0] stall_count;
  logic [1:0] wb_count;

  always #2 clk = ~clk;

  vec_scoreboard #(.CNT_W(CW)) u_vec_scoreboard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_vec_in(req_vec_in), .req_vec_out(req_vec_out),
    .req_int_in(req_int_in), .req_int_out(req_int_out), .req_cr(req_cr),
    .clr_vec(clr_vec), .clr_int(clr_int), .clr_cr(clr_cr), .clr_status(clr_status),
    .stall(stall), .stall_count(stall_count), .wb_count(wb_count));

  int checks = 0, errors = 0;
  logic [31:0] mv = '0, mi = '0;
  logic [7:0] mc = '0;
  logic ms = 1'b0, mwait = 1'b0;
  logic [CW-1:0] mcnt = '0;
  logic last_stall = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic hz(input logic [2:0] c, input logic [31:0] vi, vo, ii, io,
                              input logic [7:0] cr, input logic [31:0] ev, ei,
                              input logic [7:0] ec, input logic es);
    logic h;
    h = (ev & (vi | vo)) != 0;
    if (c == 3'd1 && (ei & (ii | io)) != 0) h = 1'b1;
    if (c == 3'd2 && (ec & cr) != 0) h = 1'b1;
    if ((c == 3'd3 || c == 3'd4 || c == 3'd5) && es) h = 1'b1;
    return h;
  endfunction

  function automatic logic [1:0] wbm(input logic [2:0] c, input logic [31:0] vo, input logic [7:0] cr);
    logic [1:0] w;
    if (c == 3'd4 || c == 3'd5) return 2'd1;
    w = (vo == 0) ? 2'd0 : (($countones(vo) == 1) ? 2'd1 : 2'd2);
    if (c == 3'd2 && cr != 0) w = w + 2'd1;
    return w;
  endfunction

  task automatic step(input logic v, input logic [2:0] c, input logic [31:0] vi, vo, ii, io,
                      input logic [7:0] cr, input logic [31:0] kv, ki,
                      input logic [7:0] kc, input logic ks);
    logic [31:0] ev, ei;
    logic [7:0] ec;
    logic es, h, mv_c;
    @(negedge clk);
    req_valid = v; req_class = c; req_vec_in = vi; req_vec_out = vo;
    req_int_in = ii; req_int_out = io; req_cr = cr;
    clr_vec = kv; clr_int = ki; clr_cr = kc; clr_status = ks;
    #1;
    ev = mv & ~kv; ei = mi & ~ki; ec = mc & ~kc; es = ms & ~ks;
    h = hz(c, vi, vo, ii, io, cr, ev, ei, ec, es);
    mv_c = (c == 3'd4 || c == 3'd5);
    chk("R1 ready", {31'd0, req_ready}, {31'd0, ~h});
    chk("R1 stall", {31'd0, stall}, {31'd0, v & h});
    chk("R3 stall count", {24'd0, stall_count}, {24'd0, mcnt});
    if (v && !h) chk("R6 writeback count", {30'd0, wb_count}, {30'd0, wbm(c, vo, cr)});
    if (v && h) begin
      if ((mwait || mv_c) && mcnt != {CW{1'b1}}) mcnt = mcnt + 1'b1;
      mwait = 1'b1;
    end else mwait = 1'b0;
    last_stall = v & h;
    if (v && !h) begin
      if (c != 3'd5) ev = ev | vo;
      if (c == 3'd1) ei = ei | io;
      if (c == 3'd2) ec = ec | cr;
      if (c == 3'd3 || c == 3'd5) es = 1'b1;
    end
    mv = ev; mi = ei; mc = ec; ms = es;
  endtask

  task automatic idle_clear();
    step(1'b0, 3'd0, 0, 0, 0, 0, 0, '1, '1, '1, 1'b1);
  endtask

  function automatic logic [31:0] rmask();
    case ($urandom % 4)
      0: return 32'd0;
      1, 2: return 32'd1 << ($urandom % 8);
      default: return (32'd1 << ($urandom % 8)) | (32'd1 << ($urandom % 32));
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] hc;
    logic [31:0] hvi, hvo, hii, hio;
    logic [7:0] hcr;
    logic hv;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10: after reset nothing is busy and the counter is zero
    step(1'b1, 3'd3, '1, '1, '1, '1, '1, 0, 0, 0, 1'b0);
    chk("R10 reset ready", {31'd0, req_ready}, 32'd1);
    idle_clear();
    // R5/R6: single destination, then a reader of it stalls
    step(1'b1, 3'd0, 0, 32'h8, 0, 0, 0, 0, 0, 0, 1'b0);
    step(1'b1, 3'd0, 32'h8, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R5 reader of busy dest stalls", {31'd0, stall}, 32'd1);
    step(1'b1, 3'd0, 32'h8, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R3 first stall uncounted", {24'd0, stall_count}, 32'd0);
    step(1'b1, 3'd0, 32'h8, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R3 second stall counted", {24'd0, stall_count}, 32'd1);
    // R9: same-cycle clear lets it issue
    step(1'b1, 3'd0, 32'h8, 0, 0, 0, 0, 32'h8, 0, 0, 1'b0);
    chk("R9 clear bypass ready", {31'd0, req_ready}, 32'd1);
    // R6: two destinations
    step(1'b1, 3'd0, 0, 32'h30, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R6 two dests", {30'd0, wb_count}, 32'd2);
    idle_clear();
    // R2: integer masks only matter for class 1
    step(1'b1, 3'd1, 0, 0, 0, 32'h20, 0, 0, 0, 0, 1'b0);
    step(1'b1, 3'd0, 0, 0, 32'h20, 0, 0, 0, 0, 0, 1'b0);
    chk("R2 int ignored by class 0", {31'd0, req_ready}, 32'd1);
    step(1'b1, 3'd1, 0, 0, 32'h20, 0, 0, 0, 0, 0, 1'b0);
    chk("R2 int hazard class 1", {31'd0, stall}, 32'd1);
    step(1'b1, 3'd1, 0, 0, 32'h20, 0, 0, 0, 32'h20, 0, 1'b0);
    idle_clear();
    // R7: condition class
    step(1'b1, 3'd2, 0, 32'h2, 0, 0, 8'h04, 0, 0, 0, 1'b0);
    chk("R7 cr adds writeback", {30'd0, wb_count}, 32'd2);
    step(1'b1, 3'd2, 0, 0, 0, 0, 8'h04, 0, 0, 0, 1'b0);
    chk("R7 cr hazard", {31'd0, stall}, 32'd1);
    step(1'b1, 3'd2, 0, 0, 0, 0, 8'h04, 0, 0, 8'h04, 1'b0);
    idle_clear();
    // R8/R4: status serialisation, moves count first stall
    step(1'b1, 3'd3, 0, 32'h1, 0, 0, 0, 0, 0, 0, 1'b0);
    hv = 1'b0;
    begin
      logic [CW-1:0] c0;
      c0 = stall_count;
      step(1'b1, 3'd5, 32'h40, 0, 0, 0, 0, 0, 0, 0, 1'b0);
      chk("R8 move-to waits on status", {31'd0, stall}, 32'd1);
      step(1'b1, 3'd5, 32'h40, 0, 0, 0, 0, 0, 0, 0, 1'b0);
      chk("R4 first move stall counted", {24'd0, stall_count}, {24'd0, c0 + 1'b1});
    end
    step(1'b1, 3'd5, 32'h40, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    chk("R6 move-to writeback", {30'd0, wb_count}, 32'd1);
    step(1'b1, 3'd4, 0, 32'h80, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R8 move-from waits on status", {31'd0, stall}, 32'd1);
    step(1'b1, 3'd4, 0, 32'h80, 0, 0, 0, 0, 0, 0, 1'b1);
    step(1'b1, 3'd0, 32'h80, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R5 move-from marks dest busy", {31'd0, stall}, 32'd1);
    step(1'b1, 3'd0, 32'h80, 0, 0, 0, 0, 32'h80, 0, 0, 1'b0);
    idle_clear();
    // R1-style random traffic against the model, holding stalled requests (R11)
    hv = 1'b0; hc = 0; hvi = 0; hvo = 0; hii = 0; hio = 0; hcr = 0;
    for (int n = 0; n < 4000; n++) begin
      if (!last_stall) begin
        hv = ($urandom % 5) != 0;
        hc = 3'($urandom % 8);
        hvi = rmask(); hvo = rmask(); hii = rmask(); hio = rmask();
        hcr = 8'(($urandom % 3 == 0) ? 0 : (1 << ($urandom % 4)));
      end
      step(hv, hc, hvi, hvo, hii, hio, hcr,
           mv & $urandom & $urandom, mi & $urandom & $urandom,
           mc & 8'($urandom) & 8'($urandom), ms & (($urandom % 3) == 0));
    end
    idle_clear();
    // R3: saturation of the narrowed counter
    step(1'b1, 3'd0, 0, 32'h100000, 0, 0, 0, 0, 0, 0, 1'b0);
    for (int n = 0; n < 300; n++)
      step(1'b1, 3'd0, 32'h100000, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R3 counter saturates", {24'd0, stall_count}, {24'd0, {CW{1'b1}}});
    step(1'b1, 3'd0, 32'h100000, 0, 0, 0, 0, 32'h100000, 0, 0, 1'b0);
    idle_clear();
    // R10: reset again clears counter and busy state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mv = '0; mi = '0; mc = '0; ms = 1'b0; mwait = 1'b0; mcnt = '0;
    step(1'b1, 3'd3, '1, '1, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R10 counter zero after reset", {24'd0, stall_count}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule